// File: doc/BRIEF.md
# Byte-Wide Atomic Word Access Bridge

This block sits between an 8-bit register bus and a bank of 32-bit registers that belong to a counter unit, such as a running count, compare values or a capture stamp. The bus can move only one byte per access. Without help, a multi-byte read could tear while the counter advances, and a multi-byte write could expose a half-written value. The bridge avoids both with a single 32-bit holding register that every word in the bank shares.

A read of byte 0 of a word copies the whole live word into the holding register and returns its low byte. A later read of byte 1, 2 or 3 returns bytes of that copy. A write of byte 1, 2 or 3 only fills the holding register. A write of byte 0 joins the new low byte with the three held bytes and sends the full word out on a commit strobe that lasts one cycle and carries the register select. The target loads the word whenever it is able to. The counters are not part of this block: their current values come in as a flat data port.

Top module: `atomic_word_bridge`

## Requirements
- R1: After a synchronous reset, `bus_rdy` and `cmt_valid` are 0 and the holding register is zero, so an upper-byte read returns 0x00.
- R2: A read of byte index 0 copies the whole 32-bit live word of the selected register into the holding register and returns its bits 7:0. `bus_rdy` is high exactly two clocks after the request cycle.
- R3: A read of byte index 1, 2 or 3 returns bits 15:8, 23:16 or 31:24 of the holding register, and never the live word, even when the live word has changed since the capture.
- R4: Every read gives exactly one `bus_rdy` pulse, two clocks after the request, with the data valid in that same cycle.
- R5: A write to byte index 1, 2 or 3 updates only that byte of the holding register. It issues no commit.
- R6: A write to byte index 0 raises `cmt_valid` for exactly one cycle, on the clock after the request. The strobe carries the addressed select on `cmt_sel` and the word {held bits 31:8, written byte} on `cmt_data`.
- R7: The holding register is shared by all registers. Upper bytes captured from one register are committed along with a low-byte write to a different register.
- R8: If `bus_rd` and `bus_wr` are both high, only the write is performed. The read gives no `bus_rdy`.
- R9: An upper-byte read with no fresh capture returns whatever the holding register still holds from earlier accesses.
- R10: `bus_addr[1:0]` is the byte index (0 = least significant) and `bus_addr[SELW+1:2]` is the register select. Register r of the live bank is `live_flat[32*r+31:32*r]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_wr | input | 1 | Write request, one cycle per access |
| bus_addr | input | SELW+2 | Register select and byte index |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with `bus_rdy` |
| bus_rdy | output | 1 | Read data valid |
| live_flat | input | 32*NREG | Live values of all registers |
| cmt_valid | output | 1 | One-cycle commit strobe |
| cmt_sel | output | SELW | Register the commit targets |
| cmt_data | output | 32 | Word to load into the target |

## Verification
Reads are tried at every byte index of several registers, each of which holds a different byte pattern. This shows that the byte index and the register select are decoded independently. Upper-byte writes followed by a low-byte write show whether the committed word is put together from held bytes and the new byte, and whether upper writes leak a commit. Changing a live word after a capture tells a read of the snapshot apart from a read of the live value. Capturing from one register and then committing to another, together with upper reads made with no fresh capture, shows that the holding register is shared and keeps its contents. A cycle with both read and write high shows which request wins.

// File: rtl/awb_pkg.sv
`timescale 1ns/1ps
package awb_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int IDX_W     = $clog2(WORD_BYTES);
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/awb_word_mux.sv
`timescale 1ns/1ps
module awb_word_mux
  import awb_pkg::*;
#(
  parameter int NREG = 4,
  parameter int SELW = 2
) (
  input  logic [NREG*WORD_W-1:0] live_flat,
  input  logic [SELW-1:0]        sel,
  output word_t                  word
);
  word_t words [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_split
    assign words[g] = live_flat[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel == i[SELW-1:0]) word = words[i];
    end
  end
endmodule

// File: rtl/awb_shadow.sv
`timescale 1ns/1ps
module awb_shadow
  import awb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap_en,
  input  word_t                 cap_word,
  input  logic [WORD_BYTES-1:0] byte_we,
  input  byte_t                 wbyte,
  output word_t                 held
);
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_byte
    byte_t q;
    always_ff @(posedge clk) begin
      if (rst)             q <= '0;
      else if (cap_en)     q <= cap_word[g*BYTE_W +: BYTE_W];
      else if (byte_we[g]) q <= wbyte;
    end
    assign held[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/awb_read_pipe.sv
`timescale 1ns/1ps
module awb_read_pipe
  import awb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] idx,
  input  word_t            held,
  output byte_t            rdata,
  output logic             rdy
);
  logic             req_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      idx_q <= '0;
      rdy   <= 1'b0;
      rdata <= '0;
    end else begin
      req_q <= req;
      idx_q <= idx;
      rdy   <= req_q;
      if (req_q) rdata <= held[{idx_q, 3'b000} +: BYTE_W];
    end
  end
endmodule

// File: rtl/atomic_word_bridge.sv
`timescale 1ns/1ps
module atomic_word_bridge
  import awb_pkg::*;
#(
  parameter int NREG = 4,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [SELW+IDX_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0]      bus_wdata,
  output logic [BYTE_W-1:0]      bus_rdata,
  output logic                   bus_rdy,
  input  logic [NREG*WORD_W-1:0] live_flat,
  output logic                   cmt_valid,
  output logic [SELW-1:0]        cmt_sel,
  output logic [WORD_W-1:0]      cmt_data
);
  logic [IDX_W-1:0]      idx;
  logic [SELW-1:0]       sel;
  logic                  rd_go, wr_go, low_byte;
  logic                  cap_en, cmt_go;
  logic [WORD_BYTES-1:0] byte_we;
  word_t                 live_word, held;

  assign idx      = bus_addr[IDX_W-1:0];
  assign sel      = bus_addr[SELW+IDX_W-1:IDX_W];
  assign wr_go    = bus_wr;
  assign rd_go    = bus_rd & ~bus_wr;
  assign low_byte = (idx == '0);
  assign cap_en   = rd_go & low_byte;
  assign cmt_go   = wr_go & low_byte;

  always_comb begin
    byte_we = '0;
    if (wr_go && !low_byte) byte_we[idx] = 1'b1;
  end

  awb_word_mux #(.NREG(NREG), .SELW(SELW)) u_mux (
    .live_flat (live_flat),
    .sel       (sel),
    .word      (live_word)
  );

  awb_shadow u_shadow (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .cap_word (live_word),
    .byte_we  (byte_we),
    .wbyte    (bus_wdata),
    .held     (held)
  );

  awb_read_pipe u_rd (
    .clk   (clk),
    .rst   (rst),
    .req   (rd_go),
    .idx   (idx),
    .held  (held),
    .rdata (bus_rdata),
    .rdy   (bus_rdy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid <= 1'b0;
      cmt_sel   <= '0;
      cmt_data  <= '0;
    end else begin
      cmt_valid <= cmt_go;
      if (cmt_go) begin
        cmt_sel  <= sel;
        cmt_data <= {held[WORD_W-1:BYTE_W], bus_wdata};
      end
    end
  end
endmodule

// File: rtl/awb_checker.sv
`timescale 1ns/1ps
module awb_checker #(
  parameter int NREG = 4,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [SELW+1:0]  bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             bus_rdy,
  input logic             cmt_valid,
  input logic [SELW-1:0]  cmt_sel,
  input logic [31:0]      cmt_data
);
  p_read_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> ##1 bus_rdy);

  p_ready_has_request_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rdy |-> $past(bus_rd && !bus_wr, 2));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wr) |=> ##1 !bus_rdy);

  p_commit_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[1:0] == 2'd0) |=> cmt_valid);

  p_no_stray_commit_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr[1:0] == 2'd0) |=> !cmt_valid);

  p_commit_fields_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[1:0] == 2'd0) |=>
      (cmt_data[7:0] == $past(bus_wdata) && cmt_sel == $past(bus_addr[SELW+1:2])));
endmodule

bind atomic_word_bridge awb_checker #(.NREG(NREG)) u_chk (.*);

// File: tb/atomic_word_bridge_test.sv
`timescale 1ns/1ps
module atomic_word_bridge_test;
  localparam int NREG = 4;
  localparam int AW = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic         bus_rdy;
  logic [127:0] live_flat;
  logic         cmt_valid;
  logic [1:0]   cmt_sel;
  logic [31:0]  cmt_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  atomic_word_bridge #(.NREG(NREG)) uut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .live_flat(live_flat), .cmt_valid(cmt_valid),
    .cmt_sel(cmt_sel), .cmt_data(cmt_data)
  );

  // register r holds bytes {r4, r3, r2, r1} (hex digits)
  localparam logic [127:0] LIVE_INIT = {32'h34333231, 32'h24232221, 32'h14131211, 32'h04030201};

  // {write, addr[3:0] = {sel, idx}, wdata, exp_rdata, exp_commit, exp_cmt_data}
  localparam int NV = 13;
  localparam logic [53:0] VEC [NV] = '{
    {1'b0, 4'b0000, 8'h00, 8'h01, 1'b0, 32'h0},         // R2 low read reg0
    {1'b0, 4'b0011, 8'h00, 8'h04, 1'b0, 32'h0},         // R3 byte3 of snapshot
    {1'b0, 4'b0001, 8'h00, 8'h02, 1'b0, 32'h0},         // R3 byte1
    {1'b0, 4'b1000, 8'h00, 8'h21, 1'b0, 32'h0},         // R10 reg2 low
    {1'b0, 4'b1010, 8'h00, 8'h23, 1'b0, 32'h0},         // R10 reg2 byte2
    {1'b1, 4'b0111, 8'hAA, 8'h00, 1'b0, 32'h0},         // R5 upper write
    {1'b1, 4'b0110, 8'hBB, 8'h00, 1'b0, 32'h0},         // R5
    {1'b1, 4'b0101, 8'hCC, 8'h00, 1'b0, 32'h0},         // R5
    {1'b0, 4'b1101, 8'h00, 8'hCC, 1'b0, 32'h0},         // R5 held byte visible
    {1'b1, 4'b0100, 8'hDD, 8'h00, 1'b1, 32'hAABBCCDD},  // R6 commit reg1
    {1'b0, 4'b0100, 8'h00, 8'h11, 1'b0, 32'h0},         // R2 reg1 low
    {1'b0, 4'b0111, 8'h00, 8'h14, 1'b0, 32'h0},         // R4 reg1 byte3
    {1'b1, 4'b1100, 8'hEE, 8'h00, 1'b1, 32'h141312EE}   // R7 reg1 bytes to reg3
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    @(posedge clk); #1;
    check(bus_rdy === 1'b1, {req, " ready"}, {31'b0, bus_rdy}, 32'h1);
    check(bus_rdata === exp, {req, " data"}, {24'b0, bus_rdata}, {24'b0, exp});
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input bit expc,
                          input logic [31:0] expd, input string req);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    check(cmt_valid === expc, {req, " commit"}, {31'b0, cmt_valid}, {31'b0, expc});
    if (expc) begin
      check(cmt_data === expd, {req, " commit data"}, cmt_data, expd);
      check(cmt_sel === a[3:2], {req, " commit sel"}, {30'b0, cmt_sel}, {30'b0, a[3:2]});
    end
    @(negedge clk); bus_wr = 1'b0;
    @(posedge clk); #1;
    check(cmt_valid === 1'b0, {req, " strobe one cycle"}, {31'b0, cmt_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    live_flat = LIVE_INIT;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check(bus_rdy === 1'b0, "R1 ready after reset", {31'b0, bus_rdy}, 32'h0);
    check(cmt_valid === 1'b0, "R1 commit after reset", {31'b0, cmt_valid}, 32'h0);
    do_read(4'b1010, 8'h00, "R1 held zero");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][53])
        do_write(VEC[i][52:49], VEC[i][48:41], VEC[i][32], VEC[i][31:0], $sformatf("vec%0d", i));
      else
        do_read(VEC[i][52:49], VEC[i][40:33], $sformatf("vec%0d", i));
    end

    // R3: live word changes after capture, upper read still gives snapshot
    do_read(4'b0000, 8'h01, "R3 capture");
    live_flat[31:0] = 32'h99999999;
    do_read(4'b0010, 8'h03, "R3 snapshot kept");
    live_flat = LIVE_INIT;

    // R8: read and write together -> write only
    @(negedge clk); bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 4'b1001; bus_wdata = 8'h5A;
    @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
    @(posedge clk); #1;
    check(bus_rdy === 1'b0, "R8 no ready", {31'b0, bus_rdy}, 32'h0);
    do_read(4'b1001, 8'h5A, "R8 write taken");

    // R9: upper read without new capture returns leftover from reg0 capture
    do_read(4'b0111, 8'h04, "R9 leftover");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule